// File: doc/BRIEF.md
# Byte FIFO with Threshold Warning Flags

A sixteen-entry, byte-wide synchronous FIFO for a DMA-style data port. An external agent watches two registered warning flags to stop moving data before the buffer runs dry or overflows. The flags are compared against a 4-bit threshold that software or a neighbouring block sets. Almost-full looks at the number of free locations. Almost-empty looks at the number of stored bytes. Each flag follows its count condition one clock after the count itself changes.

A single-cycle transfer-start pulse begins a new transfer. It empties the buffer and drives both flags to known values: almost-full low and almost-empty high. A write while full is ignored, and so is a read while empty. The read side is fall-through: the oldest stored byte is always visible on the data output. Sixteen-bit transfers are handled outside the block as two byte writes.

Top module: `thr_fifo`

## Requirements
- R1: After reset, count_o is 0, free_o is 16, empty_o is 1, full_o is 0, almost_full_o is 0 and almost_empty_o is 1.
- R2: Bytes leave in the order they were written. While empty_o is 0, rdata_o shows the oldest stored byte without waiting for a read strobe.
- R3: An accepted write raises count_o by one and an accepted read lowers it by one, both at the next clock edge. full_o is 1 exactly when count_o is 16, and empty_o is 1 exactly when count_o is 0.
- R4: free_o always equals 16 minus count_o.
- R5: When a write and a read are both accepted in the same cycle, count_o does not change and the data stays in order.
- R6: A write while full_o is 1 is ignored: the count stays at 16 and the stored bytes are unchanged. A read while empty_o is 1 is ignored and the count stays at 0.
- R7: A start_i pulse sets the count to 0 at the next edge and empties the buffer. Any write or read in that same cycle is ignored.
- R8: At the edge that samples start_i high, almost_full_o becomes 0 and almost_empty_o becomes 1.
- R9: almost_full_o is updated at each clock edge to (free_o <= thresh_i), using the free count as it stood before that edge. It therefore follows a change in free_o one clock later.
- R10: almost_empty_o is updated at each clock edge to (count_o <= thresh_i), using the count as it stood before that edge. It therefore follows a change in count_o one clock later.
- R11: Every threshold value from 0 to 15 works. With 0, almost-full is raised only when the buffer is full and almost-empty only when it is empty. With 15, almost-full is raised once one byte is stored and almost-empty drops only when the buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer-start pulse; clears the buffer and presets the flags |
| thresh_i | input | 4 | Threshold for both warning flags |
| wr_i | input | 1 | Byte write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Byte read strobe |
| rdata_o | output | 8 | Oldest stored byte (fall-through) |
| full_o | output | 1 | Buffer holds 16 bytes |
| empty_o | output | 1 | Buffer holds no bytes |
| count_o | output | 5 | Stored byte count |
| free_o | output | 5 | Free location count |
| almost_full_o | output | 1 | Registered free-count warning |
| almost_empty_o | output | 1 | Registered stored-count warning |

## Verification
The assertions take for granted that start_i, wr_i, rd_i and thresh_i hold known values from the first clock after reset. The latency properties also compare against the threshold as it was one cycle earlier, so they accept a threshold that changes at any time. The stimulus drives every input on the falling clock edge, sets the threshold before reset is released, and changes it only while the strobes are idle. Each write and read is followed by at least one idle cycle, so both flag latencies can be observed on their own.

// File: rtl/thr_fifo_pkg.sv
package thr_fifo_pkg;
  localparam int unsigned DEPTH_DEF = 16;
  localparam int unsigned DW_DEF    = 8;
  localparam int unsigned TW_DEF    = 4;

  typedef struct packed {
    logic push;
    logic pop;
    logic clr;
  } fifo_op_t;
endpackage

// File: rtl/thr_fifo_store.sv
module thr_fifo_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  thr_fifo_pkg::fifo_op_t op_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;

  // pointers wrap naturally: DEPTH must be a power of two
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (op_i.clr) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (op_i.push) wptr_q <= wptr_q + AW'(1);
      if (op_i.pop)  rptr_q <= rptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (op_i.push) mem_q[wptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rptr_q];
endmodule

// File: rtl/thr_fifo_level.sv
module thr_fifo_level #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  thr_fifo_pkg::fifo_op_t op_i,
  output logic [CW-1:0]        count_o,
  output logic [CW-1:0]        free_o,
  output logic                 full_o,
  output logic                 empty_o
);
  logic [CW-1:0] count_q, free_q;

  // count and free are separate registers stepped in opposite directions
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      free_q  <= CW'(DEPTH);
    end else if (op_i.clr) begin
      count_q <= '0;
      free_q  <= CW'(DEPTH);
    end else if (op_i.push && !op_i.pop) begin
      count_q <= count_q + CW'(1);
      free_q  <= free_q - CW'(1);
    end else if (op_i.pop && !op_i.push) begin
      count_q <= count_q - CW'(1);
      free_q  <= free_q + CW'(1);
    end
  end

  assign count_o = count_q;
  assign free_o  = free_q;
  assign full_o  = (free_q == '0);
  assign empty_o = (count_q == '0);
endmodule

// File: rtl/thr_fifo_flags.sv
module thr_fifo_flags #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TW    = 4,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] thresh_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] free_i,
  output logic          almost_full_o,
  output logic          almost_empty_o
);
  logic [CW-1:0] thr_ext;
  logic          af_q, ae_q;

  assign thr_ext = CW'(thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      af_q <= 1'b0;
      ae_q <= 1'b1;
    end else if (clr_i) begin
      af_q <= 1'b0;
      ae_q <= 1'b1;
    end else begin
      af_q <= (free_i  <= thr_ext);
      ae_q <= (count_i <= thr_ext);
    end
  end

  assign almost_full_o  = af_q;
  assign almost_empty_o = ae_q;
endmodule

// File: rtl/thr_fifo.sv
module thr_fifo #(
  parameter int unsigned DEPTH = thr_fifo_pkg::DEPTH_DEF,
  parameter int unsigned DW    = thr_fifo_pkg::DW_DEF,
  parameter int unsigned TW    = thr_fifo_pkg::TW_DEF,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] thresh_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] free_o,
  output logic          almost_full_o,
  output logic          almost_empty_o
);
  thr_fifo_pkg::fifo_op_t op;

  assign op.clr  = start_i;
  assign op.push = wr_i & ~full_o  & ~start_i;
  assign op.pop  = rd_i & ~empty_o & ~start_i;

  thr_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  thr_fifo_level #(.DEPTH(DEPTH)) u_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .count_o (count_o),
    .free_o  (free_o),
    .full_o  (full_o),
    .empty_o (empty_o)
  );

  thr_fifo_flags #(.DEPTH(DEPTH), .TW(TW)) u_flags (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clr_i          (start_i),
    .thresh_i       (thresh_i),
    .count_i        (count_o),
    .free_i         (free_o),
    .almost_full_o  (almost_full_o),
    .almost_empty_o (almost_empty_o)
  );
endmodule

// File: rtl/thr_fifo_chk.sv
module thr_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned TW    = 4,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [TW-1:0] thresh_i,
  input logic          wr_i,
  input logic [DW-1:0] wdata_i,
  input logic          rd_i,
  input logic [DW-1:0] rdata_o,
  input logic          full_o,
  input logic          empty_o,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] free_o,
  input logic          almost_full_o,
  input logic          almost_empty_o
);
  // R4
  free_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(count_o) + 32'(free_o)) == DEPTH);

  // R3
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count_o) <= DEPTH);

  // R5
  both_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && !full_o && !empty_o && !start_i) |=> $stable(count_o));

  // R6
  full_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_i && !rd_i && !start_i) |=> full_o);

  // R6
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_i && !wr_i && !start_i) |=> empty_o);

  // R7
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (count_o == '0));

  // R8
  start_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!almost_full_o && almost_empty_o));

  // R9
  af_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (almost_full_o == ($past(free_o) <= CW'($past(thresh_i)))));

  // R10
  ae_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (almost_empty_o == ($past(count_o) <= CW'($past(thresh_i)))));
endmodule

bind thr_fifo thr_fifo_chk #(.DEPTH(DEPTH), .DW(DW), .TW(TW)) u_chk (.*);

// File: tb/thr_fifo_bench.sv
`timescale 1ns/1ps
module thr_fifo_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] thresh_i = 4'd4;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       full_o, empty_o, almost_full_o, almost_empty_o;
  logic [4:0] count_o, free_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk_i = ~clk_i;

  thr_fifo u_thr_fifo (.*);

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk_i);
    wr_i = 1'b1; wdata_i = b;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic pop_chk(string req, logic [7:0] exp);
    @(negedge clk_i);
    chk(req, int'(rdata_o), int'(exp));
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", int'(count_o), 0);
    chk("R1 free", int'(free_o), 16);
    chk("R1 empty", int'(empty_o), 1);
    chk("R1 full", int'(full_o), 0);
    chk("R1 af", int'(almost_full_o), 0);
    chk("R1 ae", int'(almost_empty_o), 1);
  endtask

  task automatic t_order_ae();
    thresh_i = 4'd4;
    for (int i = 0; i < 5; i++) begin
      push(8'hA0 + 8'(i));
      chk("R3 count up", int'(count_o), i + 1);
      chk("R4 free", int'(free_o), 15 - i);
      if (i == 4) chk("R10 ae still high", int'(almost_empty_o), 1);
      idle();
    end
    chk("R10 ae low", int'(almost_empty_o), 0);
    for (int i = 0; i < 5; i++) begin
      pop_chk("R2 order", 8'hA0 + 8'(i));
      chk("R3 count down", int'(count_o), 4 - i);
      if (i == 0) begin
        chk("R10 ae low before latency", int'(almost_empty_o), 0);
        idle();
        chk("R10 ae back high", int'(almost_empty_o), 1);
      end
    end
    chk("R3 empty", int'(empty_o), 1);
  endtask

  task automatic t_full_af();
    pulse_start();
    thresh_i = 4'd3;
    for (int i = 0; i < 16; i++) begin
      push(8'(i * 7));
      if (i == 11) begin
        idle();
        chk("R9 af low free4", int'(almost_full_o), 0);
      end
      if (i == 12) begin
        chk("R9 af not yet", int'(almost_full_o), 0);
        idle();
        chk("R9 af high free3", int'(almost_full_o), 1);
      end
    end
    chk("R3 full", int'(full_o), 1);
    chk("R4 free zero", int'(free_o), 0);
    push(8'hEE);
    chk("R6 full write count", int'(count_o), 16);
    for (int i = 0; i < 16; i++) begin
      pop_chk("R6 contents kept", 8'(i * 7));
      if (i == 0) begin
        chk("R9 af held", int'(almost_full_o), 1);
        idle();
      end
      if (i == 3) begin
        idle();
        chk("R9 af low free4", int'(almost_full_o), 0);
      end
    end
  endtask

  task automatic t_both();
    pulse_start();
    thresh_i = 4'd4;
    push(8'h11); push(8'h22); push(8'h33);
    @(negedge clk_i);
    wr_i = 1'b1; rd_i = 1'b1; wdata_i = 8'h44;
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0;
    chk("R5 count kept", int'(count_o), 3);
    pop_chk("R5 order", 8'h22);
    pop_chk("R5 order", 8'h33);
    pop_chk("R5 order", 8'h44);
    @(negedge clk_i);
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    chk("R6 empty read count", int'(count_o), 0);
    chk("R6 empty read flag", int'(empty_o), 1);
  endtask

  task automatic t_start();
    pulse_start();
    thresh_i = 4'd8;
    for (int i = 0; i < 10; i++) push(8'h60 + 8'(i));
    idle();
    chk("R9 af before start", int'(almost_full_o), 1);
    chk("R10 ae before start", int'(almost_empty_o), 0);
    @(negedge clk_i);
    start_i = 1'b1; wr_i = 1'b1; rd_i = 1'b1; wdata_i = 8'hFF;
    @(negedge clk_i);
    start_i = 1'b0; wr_i = 1'b0; rd_i = 1'b0;
    chk("R7 count cleared", int'(count_o), 0);
    chk("R7 empty", int'(empty_o), 1);
    chk("R8 af forced low", int'(almost_full_o), 0);
    chk("R8 ae forced high", int'(almost_empty_o), 1);
    push(8'h5A);
    pop_chk("R7 fresh data", 8'h5A);
  endtask

  task automatic t_thresh_edges();
    pulse_start();
    thresh_i = 4'd0;
    push(8'h01);
    idle();
    chk("R11 thr0 ae low", int'(almost_empty_o), 0);
    for (int i = 1; i < 15; i++) push(8'h01);
    idle();
    chk("R11 thr0 af low at 15", int'(almost_full_o), 0);
    push(8'h01);
    idle();
    chk("R11 thr0 af high full", int'(almost_full_o), 1);
    pulse_start();
    thresh_i = 4'd15;
    idle();
    chk("R11 thr15 af empty", int'(almost_full_o), 0);
    push(8'h02);
    idle();
    chk("R11 thr15 af one byte", int'(almost_full_o), 1);
    for (int i = 1; i < 15; i++) push(8'h02);
    idle();
    chk("R11 thr15 ae at 15", int'(almost_empty_o), 1);
    push(8'h02);
    idle();
    chk("R11 thr15 ae full", int'(almost_empty_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_order_ae();
    t_full_af();
    t_both();
    t_start();
    t_thresh_edges();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule